// File: doc/BRIEF.md
# Fixed-Point Rounding Shift and Saturation Unit

This block performs the narrowing step of vector fixed-point arithmetic on one element. A wide element is shifted right by a given amount. A rounding increment, chosen by a 2-bit rounding mode, is computed from the bits that the shift drops and added to the result. The rounded value is then clamped to a narrower output width, as a signed or an unsigned number, and a saturation flag reports whether the value was clamped.

The rounding mode and the saturation flag live together in one small control/status register. Software can read and write this register. Every operation rewrites the flag: it is set when the value is clamped and cleared when it is not. By default the result is registered and appears one cycle after the operation is issued.

Top module: `fxp_narrow_unit`

## Requirements
- R1: When the shift amount is 0 the rounding increment is 0 in every mode, so the result is the element clamped to the output width.
- R2: Mode 0 (round half up): the increment is element bit (shift-1), the most significant discarded bit.
- R3: Mode 1 (round to nearest, ties to even): the increment is bit (shift-1) AND (any lower discarded bit OR bit (shift) of the element).
- R4: Mode 2 (truncate): the increment is always 0.
- R5: Mode 3 (round to odd): the increment is 1 when bit (shift) is 0 and any discarded bit is 1.
- R6: Unsigned: a rounded value above 2^OUT_W-1 gives all ones on the output and sets the flag.
- R7: Signed: a rounded value above 2^(OUT_W-1)-1 gives that maximum, and a value below -2^(OUT_W-1) gives that minimum. Either case sets the flag.
- R8: When the value is not clamped, the output is the low OUT_W bits of the rounded value and the flag is written to 0.
- R9: The control/status register reads as {mode[1:0], sat} on bits [2:0]. Reset sets it to 0. A write stores csr_wdata in the same layout.
- R10: When an operation and a software write happen in the same cycle, the flag takes the value from the operation. The mode still takes the written value.
- R11: With the registered output, res_data, res_sat and res_valid show an operation one cycle after op_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_signed | input | 1 | 1 selects signed arithmetic and clamping |
| op_elem | input | IN_W | Wide input element |
| op_shift | input | SH_W | Right-shift amount, 0 to IN_W-1 |
| res_valid | output | 1 | Result valid |
| res_data | output | OUT_W | Rounded, clamped result |
| res_sat | output | 1 | The result was clamped |
| csr_we | input | 1 | Software write strobe |
| csr_wdata | input | 3 | Write data: mode in [2:1], flag in [0] |
| csr_rdata | output | 3 | Register read value, same layout |

## Verification
The assertions check three things on every cycle. The register flag matches the flag of the last operation, even when software writes in the same cycle. A flagged result is always one of the clamp values. A zero-shift result that was not clamped is the unmodified low element bits. The rounding rules themselves, and the choice between clamping and passing a value through, can only be shown by the bench. It sweeps every element value, shift amount, mode and sign setting on a small configuration and compares against an integer round-then-clamp model.

// File: rtl/fxp_narrow_unit.sv
module fxp_narrow_unit #(
  parameter int IN_W    = 16,
  parameter int OUT_W   = 8,
  parameter bit REG_OUT = 1'b1,
  parameter int SH_W    = $clog2(IN_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_signed,
  input  logic [IN_W-1:0]  op_elem,
  input  logic [SH_W-1:0]  op_shift,
  output logic             res_valid,
  output logic [OUT_W-1:0] res_data,
  output logic             res_sat,
  input  logic             csr_we,
  input  logic [2:0]       csr_wdata,
  output logic [2:0]       csr_rdata
);
  localparam int XW = IN_W + 1;
  localparam logic [IN_W-1:0] ONE = IN_W'(1);
  localparam logic signed [XW-1:0] U_MAX = {{(XW-OUT_W){1'b0}}, {OUT_W{1'b1}}};
  localparam logic signed [XW-1:0] S_MAX = {{(XW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [XW-1:0] S_MIN = {{(XW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic [1:0] rmode;
  logic       sat_q;

  logic [IN_W-1:0]        disc_mask, low_mask;
  logic                   any_disc, any_low, half_bit, keep_bit, incr;
  logic signed [XW-1:0]   ext, shifted, rounded;
  logic [OUT_W-1:0]       clamp_data;
  logic                   clamp_hit;

  assign disc_mask = (ONE << op_shift) - ONE;
  assign low_mask  = disc_mask >> 1;
  assign any_disc  = |(op_elem & disc_mask);
  assign any_low   = |(op_elem & low_mask);
  assign half_bit  = |(op_elem & (disc_mask ^ low_mask));
  assign keep_bit  = op_elem[op_shift];

  always_comb begin
    if (op_shift == '0) incr = 1'b0;
    else begin
      unique case (rmode)
        2'd0: incr = half_bit;
        2'd1: incr = half_bit & (any_low | keep_bit);
        2'd2: incr = 1'b0;
        default: incr = ~keep_bit & any_disc;
      endcase
    end
  end

  assign ext     = {op_signed & op_elem[IN_W-1], op_elem};
  assign shifted = ext >>> op_shift;
  assign rounded = shifted + XW'(incr);

  always_comb begin
    clamp_hit  = 1'b0;
    clamp_data = rounded[OUT_W-1:0];
    if (!op_signed) begin
      if (rounded > U_MAX) begin
        clamp_hit  = 1'b1;
        clamp_data = {OUT_W{1'b1}};
      end
    end else if (rounded > S_MAX) begin
      clamp_hit  = 1'b1;
      clamp_data = {1'b0, {(OUT_W-1){1'b1}}};
    end else if (rounded < S_MIN) begin
      clamp_hit  = 1'b1;
      clamp_data = {1'b1, {(OUT_W-1){1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rmode <= 2'd0;
      sat_q <= 1'b0;
    end else begin
      if (csr_we) begin
        rmode <= csr_wdata[2:1];
        sat_q <= csr_wdata[0];
      end
      if (op_valid) sat_q <= clamp_hit;
    end
  end

  assign csr_rdata = {rmode, sat_q};

  generate
    if (REG_OUT) begin : g_reg
      logic             v_q, s_q;
      logic [OUT_W-1:0] d_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          s_q <= 1'b0;
          d_q <= '0;
        end else begin
          v_q <= op_valid;
          if (op_valid) begin
            s_q <= clamp_hit;
            d_q <= clamp_data;
          end
        end
      end
      assign res_valid = v_q;
      assign res_sat   = s_q;
      assign res_data  = d_q;

      assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
      assert_zero_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_shift == '0) |=> (res_sat || res_data == $past(op_elem[OUT_W-1:0])));
      assert_flag_tracks_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (csr_rdata[0] == res_sat));
    end else begin : g_comb
      assign res_valid = op_valid;
      assign res_sat   = clamp_hit;
      assign res_data  = clamp_data;
    end
  endgenerate

  assert_clamp_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_sat) |-> (res_data == {OUT_W{1'b1}} ||
      res_data == {1'b0, {(OUT_W-1){1'b1}}} || res_data == {1'b1, {(OUT_W-1){1'b0}}}));
  assert_csr_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !op_valid) |=> (csr_rdata == $past(csr_wdata)));
endmodule

// File: tb/fxp_narrow_unit_test.sv
module fxp_narrow_unit_test;
  localparam int IN_W = 8, OUT_W = 4, SH_W = 3;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_signed = 0, csr_we = 0;
  logic [IN_W-1:0] op_elem = '0;
  logic [SH_W-1:0] op_shift = '0;
  logic [2:0] csr_wdata = '0;
  logic res_valid, res_sat;
  logic [OUT_W-1:0] res_data;
  logic [2:0] csr_rdata;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fxp_narrow_unit #(.IN_W(IN_W), .OUT_W(OUT_W), .REG_OUT(1'b1), .SH_W(SH_W)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_signed(op_signed),
    .op_elem(op_elem), .op_shift(op_shift), .res_valid(res_valid),
    .res_data(res_data), .res_sat(res_sat), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input int md, input bit sg, input int sh, input int e,
                       output int data, output bit sat);
    int v, q, r, half, inc, res, lo, hi;
    v = sg ? int'($signed(8'(e))) : e;
    q = v >>> sh;
    r = v - (q << sh);
    half = (sh == 0) ? 0 : (1 << (sh - 1));
    inc = 0;
    if (sh != 0) begin
      case (md)
        0: inc = (r >= half) ? 1 : 0;
        1: inc = (r > half || (r == half && q[0])) ? 1 : 0;
        2: inc = 0;
        default: inc = (r != 0 && !q[0]) ? 1 : 0;
      endcase
    end
    res = q + inc;
    lo = sg ? -(1 << (OUT_W - 1)) : 0;
    hi = sg ? (1 << (OUT_W - 1)) - 1 : (1 << OUT_W) - 1;
    sat = 1'b1;
    if (res > hi) res = hi;
    else if (res < lo) res = lo;
    else sat = 1'b0;
    data = res & ((1 << OUT_W) - 1);
  endtask

  function automatic string tag_of(int md, int sh, bit sat, bit sg);
    if (sat) return sg ? "R7" : "R6";
    if (sh == 0) return "R1";
    case (md)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic csr_write(input logic [2:0] w);
    @(negedge clk);
    csr_we = 1; csr_wdata = w;
    @(negedge clk);
    csr_we = 0;
    check("R9 csr write", csr_rdata, w);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ed; bit es;
    repeat (3) @(negedge clk);
    check("R9 reset csr", csr_rdata, 0);
    check("R11 reset valid", res_valid, 0);
    rst_n = 1;
    for (int md = 0; md < 4; md++) begin
      csr_write({md[1:0], 1'b1});
      for (int sg = 0; sg < 2; sg++)
        for (int sh = 0; sh < IN_W; sh++)
          for (int e = 0; e < 256; e++) begin
            model(md, sg[0], sh, e, ed, es);
            op_valid = 1; op_signed = sg[0]; op_shift = sh[SH_W-1:0]; op_elem = e[7:0];
            @(negedge clk);
            op_valid = 0;
            check({tag_of(md, sh, es, sg[0]), " data"}, res_data, ed);
            check(es ? tag_of(md, sh, es, sg[0]) : "R8", res_sat, es);
            check("R10 flag", csr_rdata[0], es);
            if (e == 0) check("R11 valid", res_valid, 1);
          end
    end
    @(negedge clk);
    check("R11 valid drops", res_valid, 0);
    // R10: same-cycle write of flag 0 with a clamping op (unsigned 0xFF, shift 0)
    op_valid = 1; op_signed = 0; op_shift = 0; op_elem = 8'hFF;
    csr_we = 1; csr_wdata = 3'b100;
    @(negedge clk);
    op_valid = 0; csr_we = 0;
    check("R10 op wins (set)", csr_rdata, 3'b101);
    // R10: same-cycle write of flag 1 with a non-clamping op
    op_valid = 1; op_signed = 0; op_shift = 0; op_elem = 8'h03;
    csr_we = 1; csr_wdata = 3'b011;
    @(negedge clk);
    op_valid = 0; csr_we = 0;
    check("R10 op wins (clear)", csr_rdata, 3'b010);
    check("R8 low bits", res_data, 3);
    csr_write(3'b000);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule